// File: doc/BRIEF.md
# I2S Master Transmit Serializer

This block drives an I2S-style serial audio link as bus master. From the system clock it derives a bit clock whose period is a programmable number of system clocks. It also drives a word-select line that marks the left and right channel slots, and a serial data line. Parallel 32-bit samples are written into a small transmit FIFO. At the start of each channel slot one sample is taken from the FIFO and shifted out most-significant bit first.

Each slot is 40 bit clocks long. The data line stays at zero for the first bit time of a slot, carries the 32 sample bits in bit times 1 to 32, and returns to zero for the remaining bit times. An interrupt line reports that the FIFO has drained to a byte threshold that software programs. A sticky flag records any slot that started while the FIFO was empty. A single enable input starts and stops the link. While the link is stopped, the clock, the divider and the threshold may be changed and the FIFO may be preloaded.

Top module: `i2s_tx_master`

## Requirements
- R1: While enabled, sclk_o has a period of div_i system clocks (div_i even, at least 2). It is low for the first half of the period and high for the second half.
- R2: After enable, the first slot has lrck_o low (left). Every slot lasts exactly 40 sclk_o periods, and lrck_o toggles at each slot boundary, so a frame is 80 periods.
- R3: sdata_o and lrck_o change only together with a falling edge of sclk_o, so a receiver samples them on the rising edge.
- R4: A sample is sent MSB first. Its bit 31 is in bit time 1 of the slot, one sclk_o period after lrck_o changed, and its bit 0 is in bit time 32.
- R5: sdata_o is 0 in bit time 0 and in bit times 33 to 39 of every slot.
- R6: The FIFO holds 8 samples and delivers them in write order, one at the start of each slot. wr_ready_o is low when the FIFO is full, and a write at that time is dropped.
- R7: A slot that starts with an empty FIFO sends all zeros and sets underrun_o. underrun_o stays set until en_i is low.
- R8: irq_o equals irq_en_i AND (4 × FIFO level ≤ alarm_bytes_i), where the level is counted in 32-bit samples.
- R9: While en_i is low, sclk_o is high and lrck_o and sdata_o are low. FIFO contents are kept, and the next enable restarts the frame at the left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the link; low stops it for configuration |
| div_i | input | DIV_W | Bit clock period in system clocks |
| alarm_bytes_i | input | ALARM_W | FIFO alarm threshold in bytes |
| irq_en_i | input | 1 | Interrupt enable |
| wr_valid_i | input | 1 | Write a sample into the FIFO |
| wr_data_i | input | DATA_W | Sample to write |
| wr_ready_o | output | 1 | FIFO can take a sample |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Word select, low for the left slot |
| sdata_o | output | 1 | Serial data |
| irq_o | output | 1 | Transmit-ready interrupt |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
A loopback receiver in the bench rebuilds every slot from the rising edges of sclk_o. It compares each slot with the scoreboard and checks every zero-filled bit time. A design that started the data in bit time 0, or that filled slots to a width other than 40, would fail the per-bit checks and the slot-length checks. The bench fills the FIFO completely and then writes one more sample. A design that accepted that write would send it in place of the expected zero slot. The bench lets the FIFO run empty to check the sticky underrun flag and how it is cleared. It steps the FIFO level across the byte threshold to catch an off-by-one in the alarm compare. It also runs the smallest divider, so that a wrong half-period would show up in the measured sclk_o period.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic {
    SLOT_LEFT  = 1'b0,
    SLOT_RIGHT = 1'b1
  } slot_e;
endpackage

// File: rtl/i2s_sclk_gen.sv
module i2s_sclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             fall_o,
  output logic             run_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half;
  logic             run_q, sclk_q, rise;

  assign half   = div_i >> 1;
  // the first tick after enable starts the first bit time
  assign fall_o = en_i && (!run_q || cnt_q == div_i - 1'b1);
  assign rise   = en_i && run_q && (cnt_q == half - 1'b1);
  assign sclk_o = sclk_q;
  assign run_o  = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      sclk_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      sclk_q <= 1'b1;
    end else begin
      run_q <= 1'b1;
      cnt_q <= fall_o ? '0 : cnt_q + 1'b1;
      if (fall_o)    sclk_q <= 1'b0;
      else if (rise) sclk_q <= 1'b1;
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> sclk_o); // R9

  AST_FALL_LOWERS_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> (!sclk_o || !$past(en_i))); // R1
endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             ready_o,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  output logic [LVL_W-1:0] level_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign ready_o = (level_q != LVL_W'(DEPTH));
  assign valid_o = (level_q != '0);
  assign push_ok = push_i && ready_o;
  assign pop_ok  = pop_i && valid_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o); // R7

  AST_FULL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && push_i && !pop_i) |=> $stable(level_q)); // R6
endmodule

// File: rtl/i2s_slot_ser.sv
module i2s_slot_ser
  import i2s_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SLOT_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              fifo_valid_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              pop_o,
  output logic              lrck_o,
  output logic              sdata_o,
  output logic              underrun_o
);
  localparam int unsigned BIT_W = $clog2(SLOT_W);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(SLOT_W - 1);
  localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(DATA_W);

  slot_e             slot_q, slot_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] sh_q;
  logic              sd_q, urun_q, load;

  always_comb begin
    bit_d  = bit_q + 1'b1;
    slot_d = slot_q;
    if (!run_i) begin
      bit_d  = '0;
      slot_d = SLOT_LEFT;
    end else if (bit_q == LAST_BIT) begin
      bit_d  = '0;
      slot_d = (slot_q == SLOT_LEFT) ? SLOT_RIGHT : SLOT_LEFT;
    end
  end

  assign load       = tick_i && (bit_d == '0);
  assign pop_o      = load && fifo_valid_i;
  assign lrck_o     = (slot_q == SLOT_RIGHT);
  assign sdata_o    = sd_q;
  assign underrun_o = urun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      slot_q <= SLOT_LEFT;
      sh_q   <= '0;
      sd_q   <= 1'b0;
      urun_q <= 1'b0;
    end else if (!en_i) begin
      bit_q  <= '0;
      slot_q <= SLOT_LEFT;
      sh_q   <= '0;
      sd_q   <= 1'b0;
      urun_q <= 1'b0;
    end else if (tick_i) begin
      bit_q  <= bit_d;
      slot_q <= slot_d;
      if (load) begin
        // bit time 0 is a zero gap; the sample starts one bit later
        sh_q <= fifo_valid_i ? fifo_data_i : '0;
        sd_q <= 1'b0;
        if (!fifo_valid_i) urun_q <= 1'b1;
      end else if (bit_d <= LAST_DATA) begin
        sd_q <= sh_q[DATA_W-1];
        sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      end else begin
        sd_q <= 1'b0;
      end
    end
  end

  AST_GAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (bit_q == '0 || bit_q > LAST_DATA)) |-> !sdata_o); // R5

  AST_LRCK_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && run_i && bit_q != LAST_BIT) |=> (!en_i || $stable(slot_q))); // R2

  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && urun_q) |=> (urun_q || !$past(en_i))); // R7
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SLOT_W     = 40,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned ALARM_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [ALARM_W-1:0] alarm_bytes_i,
  input  logic              irq_en_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic              sdata_o,
  output logic              irq_o,
  output logic              underrun_o
);
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned BYTES = DATA_W / 8;

  logic              tick, run, pop, f_valid;
  logic [DATA_W-1:0] f_data;
  logic [LVL_W-1:0]  level;
  logic [ALARM_W-1:0] level_bytes;

  i2s_sclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .div_i (div_i),
    .sclk_o(sclk_o),
    .fall_o(tick),
    .run_o (run)
  );

  i2s_tx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (wr_valid_i),
    .data_i (wr_data_i),
    .ready_o(wr_ready_o),
    .pop_i  (pop),
    .valid_o(f_valid),
    .data_o (f_data),
    .level_o(level)
  );

  i2s_slot_ser #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .tick_i      (tick),
    .run_i       (run),
    .fifo_valid_i(f_valid),
    .fifo_data_i (f_data),
    .pop_o       (pop),
    .lrck_o      (lrck_o),
    .sdata_o     (sdata_o),
    .underrun_o  (underrun_o)
  );

  assign level_bytes = ALARM_W'(level) * ALARM_W'(BYTES);
  assign irq_o       = irq_en_i && (level_bytes <= alarm_bytes_i);

  AST_SDATA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(sdata_o)) |-> !sclk_o); // R3

  AST_LRCK_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(lrck_o)) |-> !sclk_o); // R3
endmodule

// File: tb/i2s_tx_master_test.sv
`timescale 1ns/1ps
module i2s_tx_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  div = 8'd16;
  logic [7:0]  alarm = 8'd16;
  logic        irq_en = 1'b1;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, sclk, lrck, sdata, irq, urun;

  int checks = 0;
  int bad = 0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  i2s_tx_master uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div),
    .alarm_bytes_i(alarm), .irq_en_i(irq_en), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .wr_ready_o(wr_ready), .sclk_o(sclk),
    .lrck_o(lrck), .sdata_o(sdata), .irq_o(irq), .underrun_o(urun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d);
    logic acc;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    acc      = wr_ready;
    @(negedge clk);
    wr_valid = 1'b0;
    if (acc) exp_q.push_back(d);
  endtask

  // loopback receiver / scoreboard monitor
  int          idx = -1;
  int          words_done = 0;
  int          cyc = 0;
  bit          have_rise = 1'b0;
  logic        prev_lr = 1'b0;
  logic        sclk_prev = 1'b1;
  logic [31:0] word = '0;

  always @(negedge clk) begin
    logic [31:0] e;
    if (!en || !rst_n) begin
      idx = -1;
      have_rise = 1'b0;
      prev_lr = 1'b0;
      cyc = 0;
    end else begin
      cyc++;
      if (sclk && !sclk_prev) begin
        if (have_rise) chk(cyc == int'(div), "R1 sclk period", cyc, div);
        have_rise = 1'b1;
        cyc = 0;
        if (idx < 0) begin
          chk(lrck == 1'b0, "R2 first slot left", lrck, 0);
          idx = 0;
        end else if (lrck != prev_lr) begin
          chk(idx == 39, "R2 slot length", idx + 1, 40);
          idx = 0;
        end else begin
          idx++;
          if (idx > 39) chk(1'b0, "R2 slot too long", idx + 1, 40);
        end
        prev_lr = lrck;
        if (idx == 0 || idx > 32) chk(sdata == 1'b0, "R5 zero bit time", sdata, 0);
        else word = {word[30:0], sdata};
        if (idx == 39) begin
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h0;
          chk(word === e, "R4 R6 R7 slot word", word, e);
          words_done++;
        end
      end
    end
    sclk_prev = sclk;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1 && lrck == 1'b0 && sdata == 1'b0, "R9 reset idle", {sclk, lrck, sdata}, 3'b100);
    chk(urun == 1'b0, "R7 reset", urun, 0);
    chk(wr_ready == 1'b1, "R6 reset ready", wr_ready, 1);
    chk(irq == 1'b1, "R8 empty alarm", irq, 1);

    // preload to full; irq follows byte level
    begin
      logic [31:0] pat [8] = '{32'hA5C3_0F81, 32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0001,
                               32'h1234_5678, 32'hDEAD_BEEF, 32'h7FFF_FFFE, 32'hC0FF_EE00};
      for (int i = 0; i < 8; i++) begin
        push(pat[i]);
        chk(irq == ((i + 1) * 4 <= 16), "R8 level vs threshold", irq, (i + 1) * 4 <= 16);
      end
    end
    @(negedge clk);
    chk(wr_ready == 1'b0, "R6 full", wr_ready, 0);
    push(32'h5555_AAAA); // dropped: expected to never appear
    irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R8 enable gate", irq, 0);
    irq_en = 1'b1;
    alarm = 8'd16;
    repeat (20) @(negedge clk);
    chk(sclk == 1'b1 && lrck == 1'b0 && sdata == 1'b0, "R9 held while disabled", {sclk, lrck, sdata}, 3'b100);

    en = 1'b1;
    base = words_done;
    wait (words_done == base + 3);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R8 five left", irq, 0);
    wait (words_done == base + 4);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R8 four left", irq, 1);
    wait (words_done == base + 8);
    repeat (2) @(negedge clk);
    chk(urun == 1'b0, "R7 no underrun yet", urun, 0);
    wait (words_done == base + 9);
    repeat (2) @(negedge clk);
    chk(urun == 1'b1, "R7 underrun set", urun, 1);
    wait (words_done == base + 10);
    repeat (2) @(negedge clk);
    chk(urun == 1'b1, "R7 underrun sticky", urun, 1);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk(urun == 1'b0, "R7 cleared by disable", urun, 0);
    chk(sclk == 1'b1 && lrck == 1'b0 && sdata == 1'b0, "R9 stop idle", {sclk, lrck, sdata}, 3'b100);

    // faster clock, writes while running
    div = 8'd4;
    alarm = 8'd4;
    push(32'h0F0F_1234);
    chk(irq == 1'b1, "R8 one word at 4 bytes", irq, 1);
    push(32'h8888_0001);
    chk(irq == 1'b0, "R8 two words at 4 bytes", irq, 0);
    push(32'h3C3C_C3C3);
    en = 1'b1;
    base = words_done;
    push(32'hFEDC_BA98);
    push(32'h0000_8000);
    wait (words_done == base + 7);
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);

    // minimum divider
    div = 8'd2;
    push(32'h9ABC_DEF0);
    push(32'h0123_4567);
    en = 1'b1;
    base = words_done;
    wait (words_done == base + 3);
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all samples sent", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule